// File: doc/BRIEF.md
# Index-Controlled Up/Down Counter

This block keeps a 24-bit position count that steps up or down on one-cycle count strobes. It also owns a preset register and an output latch. A single asynchronous control pin, the index input, can be assigned one of four jobs:

- load the counter from the preset register;
- copy the counter into the output latch;
- hold the counter while the pin is active;
- clear the counter.

Two configuration fields set the pin's job, its active polarity, and whether it acts once per transition (pulse) or on every cycle it is active (level).

Software drives three commands that work whatever the pin is set to: load from preset, clear, and copy to the latch. The latch gives a stable snapshot of a moving count, and a pin-triggered capture records an exact mechanical position. The pin passes through a two-stage synchronizer. A pulse of 80 ns, which is ten cycles of the 125 MHz clock, is caught reliably.

Top module: `index_counter`

## Requirements
- R1: After reset the counter, the output latch and the preset register all read zero.
- R2: With no load, clear or hold in effect, cnt_up alone adds one, cnt_dn alone subtracts one, and both or neither leave the count unchanged. Arithmetic wraps modulo 2^24: 0xFFFFFF plus one gives 0, and 0 minus one gives 0xFFFFFF.
- R3: preset_wr stores preset_din in the preset register. cmd_load copies the preset register into the counter at the next rising edge.
- R4: cmd_clear zeroes the counter at the next rising edge. A clear takes priority over a load and over count strobes in the same cycle.
- R5: cmd_latch copies into output latch the counter value held before that edge. Without a capture, the latch keeps its value while the counter moves.
- R6: zcfg[2] enables the pin. When zcfg[2] is 0, the pin has no effect on the counter or the latch.
- R7: zcfg[1] selects pulse (1) or level (0) qualification. zcfg[0] selects active-high (1) or active-low (0). So code 111 means pulse active-high, 110 pulse active-low, 101 level active-high and 100 level active-low.
- R8: zfunc selects the pin's job: 00 load from preset, 01 gate, 10 capture to latch, 11 clear.
- R9: In pulse mode, each transition of the pin into its active level causes one action. This includes pulses of 80 ns. The action lands on the third rising edge after the pin changes. Holding the pin active afterwards causes no further action.
- R10: In level mode, the load or clear is applied on every cycle the synchronized pin is active. Counting resumes on the third rising edge after the pin goes inactive.
- R11: In gate mode, strobes are ignored while the synchronized pin is at its active level, whatever the value of zcfg[1]. The opposite level lets the counter step.
- R12: A pin-triggered load or clear takes priority over a count strobe in the same cycle.
- R13: A pin-triggered capture stores the counter value held just before the capture edge, even when the counter steps on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_up | input | 1 | Count-up strobe |
| cnt_dn | input | 1 | Count-down strobe |
| z_pin | input | 1 | Asynchronous index/control pin |
| zcfg | input | 3 | Pin enable, pulse/level select, polarity |
| zfunc | input | 2 | Pin function select |
| preset_wr | input | 1 | Write strobe for preset register |
| preset_din | input | 24 | Preset write data |
| cmd_load | input | 1 | Software load of counter from preset |
| cmd_clear | input | 1 | Software clear of counter |
| cmd_latch | input | 1 | Software copy of counter to latch |
| count_o | output | 24 | Current counter value |
| latch_o | output | 24 | Output latch value |

## Verification
The hardest case to reach is an index event landing on the same edge as a count step. The synchronizer hides the exact cycle in which the pin acts.

The stimulus holds a count strobe high continuously and changes the pin at a known falling edge. This puts the action on a predictable edge three cycles later. The bench records the count one edge before that action. It then checks three things: a capture stores the recorded value while the counter still steps, and a load or clear wins over the strobe on that edge. The same fixed latency lets the bench check that a pin held active in pulse mode acts only once.

// File: rtl/idxc_pkg.sv
package idxc_pkg;

  typedef enum logic [1:0] {
    ZF_LOAD = 2'b00,
    ZF_GATE = 2'b01,
    ZF_CAPT = 2'b10,
    ZF_CLR  = 2'b11
  } zfunc_e;

  typedef struct packed {
    logic load;
    logic clear;
    logic capture;
    logic hold;
  } zact_t;

  localparam int unsigned ZCFG_EN_BIT    = 2;
  localparam int unsigned ZCFG_PULSE_BIT = 1;
  localparam int unsigned ZCFG_POL_BIT   = 0;

endpackage

// File: rtl/idxc_zqual.sv
module idxc_zqual
  import idxc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        z_pin,
  input  logic [2:0]  zcfg,
  input  logic [1:0]  zfunc,
  output zact_t       zact
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   act_prev_q;
  logic                   act_now;
  logic                   trig;

  // synchronizer chain, length set by parameter
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_head
      assign sync_d[g] = z_pin;
    end else begin : g_tail
      assign sync_d[g] = sync_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      act_prev_q <= 1'b0;
    end else begin
      sync_q     <= sync_d;
      act_prev_q <= act_now;
    end
  end

  always_comb begin
    act_now = zcfg[ZCFG_POL_BIT] ? sync_q[LAST] : ~sync_q[LAST];
    trig    = zcfg[ZCFG_PULSE_BIT] ? (act_now & ~act_prev_q) : act_now;
  end

  always_comb begin
    zact = '0;
    if (zcfg[ZCFG_EN_BIT]) begin
      unique case (zfunc_e'(zfunc))
        ZF_LOAD: zact.load    = trig;
        ZF_GATE: zact.hold    = act_now;
        ZF_CAPT: zact.capture = trig;
        ZF_CLR:  zact.clear   = trig;
        default: zact         = '0;
      endcase
    end
  end

endmodule

// File: rtl/idxc_count.sv
module idxc_count #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             do_load,
  input  logic             do_clear,
  input  logic             do_hold,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;
  logic             step_any;

  always_comb begin
    step_any = (step_up ^ step_dn) & ~do_hold;
    count_en = do_clear | do_load | step_any;
    if (do_clear) begin
      count_d = '0;
    end else if (do_load) begin
      count_d = preset;
    end else if (step_up) begin
      count_d = count_q + ONE;
    end else begin
      count_d = count_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;

endmodule

// File: rtl/idxc_hold.sv
module idxc_hold #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset_wr,
  input  logic [CNT_W-1:0] preset_din,
  input  logic             capture,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] preset_q,
  output logic [CNT_W-1:0] latch_q
);

  logic [CNT_W-1:0] preset_r;
  logic [CNT_W-1:0] latch_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_r <= '0;
    end else if (preset_wr) begin
      preset_r <= preset_din;
    end
  end

  // the latch takes the registered count, i.e. the value before this edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_r <= '0;
    end else if (capture) begin
      latch_r <= count;
    end
  end

  assign preset_q = preset_r;
  assign latch_q  = latch_r;

endmodule

// File: rtl/index_counter.sv
module index_counter
  import idxc_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  input  logic             z_pin,
  input  logic [2:0]       zcfg,
  input  logic [1:0]       zfunc,
  input  logic             preset_wr,
  input  logic [CNT_W-1:0] preset_din,
  input  logic             cmd_load,
  input  logic             cmd_clear,
  input  logic             cmd_latch,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] latch_o
);

  logic             rst_meta_q;
  logic             rst_sync_n;
  zact_t            zact;
  logic [CNT_W-1:0] preset_q;
  logic             do_load;
  logic             do_clear;
  logic             do_capture;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  idxc_zqual #(.SYNC_STAGES(SYNC_STAGES)) u_zqual (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .z_pin (z_pin),
    .zcfg  (zcfg),
    .zfunc (zfunc),
    .zact  (zact)
  );

  always_comb begin
    do_load    = zact.load    | cmd_load;
    do_clear   = zact.clear   | cmd_clear;
    do_capture = zact.capture | cmd_latch;
  end

  idxc_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step_up  (cnt_up),
    .step_dn  (cnt_dn),
    .do_load  (do_load),
    .do_clear (do_clear),
    .do_hold  (zact.hold),
    .preset   (preset_q),
    .count    (count_o)
  );

  idxc_hold #(.CNT_W(CNT_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .preset_wr  (preset_wr),
    .preset_din (preset_din),
    .capture    (do_capture),
    .count      (count_o),
    .preset_q   (preset_q),
    .latch_q    (latch_o)
  );

endmodule

// File: rtl/idxc_checker.sv
module idxc_checker
  import idxc_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_up,
  input logic             cnt_dn,
  input logic [2:0]       zcfg,
  input logic             cmd_load,
  input logic             cmd_clear,
  input logic             cmd_latch,
  input zact_t            zact,
  input logic [CNT_W-1:0] preset_q,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] latch_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic any_clr;
  logic any_ld;
  logic any_cap;
  assign any_clr = zact.clear | cmd_clear;
  assign any_ld  = zact.load | cmd_load;
  assign any_cap = zact.capture | cmd_latch;

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_clr |=> (count_o == '0));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ld && !any_clr) |=> (count_o == $past(preset_q)));

  p_capture_r13: assert property (@(posedge clk) disable iff (!rst_n)
    any_cap |=> (latch_o == $past(count_o)));

  p_latch_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cap |=> $stable(latch_o));

  p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (zact.hold && !any_ld && !any_clr) |=> $stable(count_o));

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_up && !cnt_dn && !zact.hold && !any_ld && !any_clr)
      |=> (CNT_W'(count_o - $past(count_o)) == ONE));

  p_step_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_dn && !cnt_up && !zact.hold && !any_ld && !any_clr)
      |=> (CNT_W'($past(count_o) - count_o) == ONE));

  p_pin_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !zcfg[ZCFG_EN_BIT] |-> (zact == '0));

  p_one_job_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(zact));

endmodule

bind index_counter idxc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cnt_up    (cnt_up),
  .cnt_dn    (cnt_dn),
  .zcfg      (zcfg),
  .cmd_load  (cmd_load),
  .cmd_clear (cmd_clear),
  .cmd_latch (cmd_latch),
  .zact      (zact),
  .preset_q  (preset_q),
  .count_o   (count_o),
  .latch_o   (latch_o)
);

// File: tb/index_counter_bench.sv
module index_counter_bench;

  logic        clk;
  logic        rst_n;
  logic        cnt_up, cnt_dn, z_pin;
  logic [2:0]  zcfg;
  logic [1:0]  zfunc;
  logic        preset_wr;
  logic [23:0] preset_din;
  logic        cmd_load, cmd_clear, cmd_latch;
  logic [23:0] count_o, latch_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  index_counter u_index_counter (
    .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .z_pin(z_pin), .zcfg(zcfg), .zfunc(zfunc),
    .preset_wr(preset_wr), .preset_din(preset_din),
    .cmd_load(cmd_load), .cmd_clear(cmd_clear), .cmd_latch(cmd_latch),
    .count_o(count_o), .latch_o(latch_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_count(input logic [23:0] v);
    preset_din = v; preset_wr = 1'b1; tick(1);
    preset_wr = 1'b0; cmd_load = 1'b1; tick(1);
    cmd_load = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 count", count_o, 24'h0);
    chk("R1 latch", latch_o, 24'h0);
    cmd_load = 1'b1; tick(1); cmd_load = 1'b0;
    chk("R1 preset", count_o, 24'h0);
  endtask

  task automatic t_updown;
    cnt_up = 1'b1; tick(3); cnt_up = 1'b0;
    chk("R2 up", count_o, 24'd3);
    cnt_dn = 1'b1; tick(1); cnt_dn = 1'b0;
    chk("R2 down", count_o, 24'd2);
    cnt_up = 1'b1; cnt_dn = 1'b1; tick(2); cnt_up = 1'b0; cnt_dn = 1'b0;
    chk("R2 both", count_o, 24'd2);
  endtask

  task automatic t_wrap;
    set_count(24'hFFFFFF);
    chk("R3 load", count_o, 24'hFFFFFF);
    cnt_up = 1'b1; tick(1); cnt_up = 1'b0;
    chk("R2 wrap up", count_o, 24'h0);
    cnt_dn = 1'b1; tick(1); cnt_dn = 1'b0;
    chk("R2 wrap down", count_o, 24'hFFFFFF);
  endtask

  task automatic t_cmds;
    logic [23:0] snap;
    set_count(24'h000040);
    cmd_clear = 1'b1; cmd_load = 1'b1; cnt_up = 1'b1; tick(1);
    cmd_clear = 1'b0; cmd_load = 1'b0;
    chk("R4 clear wins", count_o, 24'h0);
    tick(4);
    snap = count_o;
    cmd_latch = 1'b1; tick(1); cmd_latch = 1'b0;
    chk("R5 latch", latch_o, snap);
    tick(3); cnt_up = 1'b0;
    chk("R5 latch kept", latch_o, snap);
  endtask

  task automatic t_pin_off;
    set_count(24'd7);
    zcfg = 3'b011; zfunc = 2'b11;
    z_pin = 1'b1; tick(10); z_pin = 1'b0; tick(4);
    chk("R6 pin off", count_o, 24'd7);
  endtask

  task automatic t_pulse_clear;
    set_count(24'h000099);
    zcfg = 3'b111; zfunc = 2'b11; tick(4);
    z_pin = 1'b1; tick(2);
    chk("R9 not yet", count_o, 24'h000099);
    tick(1);
    chk("R9 clear edge3", count_o, 24'h0);
    cnt_up = 1'b1; tick(5); cnt_up = 1'b0;
    chk("R9 once only", count_o, 24'd5);
    z_pin = 1'b0; tick(4);
    zcfg = 3'b000;
  endtask

  task automatic t_pulse_load_inv;
    set_count(24'h000500);
    zcfg = 3'b000; z_pin = 1'b1; tick(4);
    preset_din = 24'h123456; preset_wr = 1'b1; tick(1); preset_wr = 1'b0;
    zcfg = 3'b110; zfunc = 2'b00; tick(4);
    z_pin = 1'b0; cnt_dn = 1'b1; tick(2);
    chk("R7 inverted pre", count_o, 24'h0004FE);
    tick(1); cnt_dn = 1'b0;
    chk("R12 load beats dn", count_o, 24'h123456);
    tick(7); z_pin = 1'b1; tick(4);
    chk("R7 active-low load", count_o, 24'h123456);
    zcfg = 3'b000; z_pin = 1'b0; tick(4);
  endtask

  task automatic t_level_clear;
    set_count(24'h000020);
    zcfg = 3'b101; zfunc = 2'b11; tick(3);
    cnt_up = 1'b1; z_pin = 1'b1; tick(8);
    chk("R10 level clear holds 0", count_o, 24'h0);
    z_pin = 1'b0; tick(3);
    chk("R10 resume", count_o, 24'd1);
    tick(1); cnt_up = 1'b0;
    chk("R10 resume 2", count_o, 24'd2);
    zcfg = 3'b000;
  endtask

  task automatic t_gate;
    set_count(24'h000010);
    zcfg = 3'b111; zfunc = 2'b01; tick(3);
    cnt_up = 1'b1; z_pin = 1'b1; tick(2);
    chk("R11 gate latency", count_o, 24'h000012);
    tick(4);
    chk("R11 gated", count_o, 24'h000012);
    z_pin = 1'b0; tick(2);
    chk("R11 still gated", count_o, 24'h000012);
    tick(1); cnt_up = 1'b0;
    chk("R11 released", count_o, 24'h000013);
    zcfg = 3'b000;
  endtask

  task automatic t_capture;
    logic [23:0] snap;
    set_count(24'h000300);
    zcfg = 3'b111; zfunc = 2'b10; tick(3);
    cnt_up = 1'b1; z_pin = 1'b1; tick(2);
    snap = count_o;
    tick(1);
    chk("R13 capture value", latch_o, snap);
    chk("R13 counter stepped", count_o, snap + 24'd1);
    tick(5); cnt_up = 1'b0;
    chk("R13 single capture", latch_o, snap);
    z_pin = 1'b0; tick(4);
    cnt_up = 1'b1; snap = count_o; cmd_latch = 1'b1; tick(1);
    cmd_latch = 1'b0; cnt_up = 1'b0;
    chk("R5 cmd latch moving", latch_o, snap);
    zcfg = 3'b000;
  endtask

  initial begin
    rst_n = 1'b0; cnt_up = 1'b0; cnt_dn = 1'b0; z_pin = 1'b0;
    zcfg = 3'b000; zfunc = 2'b00; preset_wr = 1'b0; preset_din = '0;
    cmd_load = 1'b0; cmd_clear = 1'b0; cmd_latch = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_updown();
    t_wrap();
    t_cmds();
    t_pin_off();
    t_pulse_clear();
    t_pulse_load_inv();
    t_level_clear();
    t_gate();
    t_capture();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule